// File: doc/BRIEF.md
# Sparse Bit Scanner

The scanner walks a run of consecutive words in a bitmap held in a synchronous memory with one cycle of read latency. It reports the absolute index of every set bit, one index per accepted transfer. Within a word the lowest set bit comes first, and words are visited in address order. The lowest set bit is found with the arithmetic identity w & (w ^ (w - 1)), which leaves exactly one bit standing. A plain OR-tree encoder turns that one-hot mask into a bit number, and the bit is then cleared from the working word. No wide priority encoder is used anywhere.

A caller pulses a start strobe with a base word address and a word count. Reads stream out while the current word is being drained. Words that read back as zero are dropped as soon as they arrive, so a mostly empty bitmap costs about one cycle per word. The index stream uses valid/ready flow control and marks its final entry with a last flag. A scan that finds no set bit ends with a single done pulse instead.

Top module: `sparse_bit_scanner`

## Requirements
- R1: After reset, out_valid_o, mem_req_o, done_o and busy_o are all 0.
- R2: Every set bit in the scanned words is reported exactly once as index = word_address*WORD_W + bit_number. Word addresses run from base_i upward and wrap modulo 2^ADDR_W.
- R3: Indices are reported in scan order: words in address order, and within one word from bit 0 upward.
- R4: The isolated mask has at most one bit set. When the working word is nonzero, that bit is the word's lowest set bit.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_pos_o and out_last_o hold their values.
- R6: out_last_o is high on the final reported index of a scan and on no other transfer.
- R7: Zero words issue one read per cycle. A scan of N all-zero words raises done_o no later than N+4 cycles after the start is accepted.
- R8: A start with count_i = 0 issues no read, reports nothing, and pulses done_o.
- R9: done_o pulses for one cycle only when a scan reported no index. After any scan ends, busy_o is 0.
- R10: A start pulse while busy_o is high is ignored, and the running scan's results are unchanged.
- R11: With out_ready_i held high and every scanned word nonzero, indices are accepted on consecutive cycles from the first to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| base_i | input | ADDR_W | First word address |
| count_i | input | ADDR_W+1 | Number of words to scan |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan with no set bit |
| mem_req_o | output | 1 | Read strobe |
| mem_addr_o | output | ADDR_W | Read word address |
| mem_rdata_i | input | WORD_W | Read data, valid one cycle after the strobe |
| out_valid_o | output | 1 | Index available |
| out_ready_i | input | 1 | Consumer accepts the index |
| out_pos_o | output | ADDR_W+log2(WORD_W) | Absolute bit index |
| out_last_o | output | 1 | Final index of the scan |

## Verification
The assertions check several properties on every cycle:
- the isolated mask is one-hot and is the lowest bit of the working word;
- the output holds steady under backpressure;
- no arriving word overwrites an occupied prefetch slot;
- indices from the same word rise;
- no transfer follows the one marked last;
- done never coincides with a valid index.

Other behaviour can only be shown by the bench's scenarios. These are completeness against a software list of set bits, correct handling of address wrap, the cycle bound for all-zero runs, back-to-back throughput on dense words, and ignoring a start pulse issued mid-scan.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_BUSY = 1'b1
    } scan_mode_e;

    // Mask of all bit indices i (i < 64) whose binary digit k is one.
    function automatic logic [63:0] digit_mask(input int k);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (((i >> k) & 1) == 1) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sbs_lowbit.sv
module sbs_lowbit #(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] iso_o,
    output logic [WORD_W-1:0] rest_o
);
    logic [WORD_W-1:0] dec;

    always_comb begin
        dec    = word_i - WORD_W'(1);
        iso_o  = word_i & (word_i ^ dec);
        rest_o = word_i ^ iso_o;
    end

    // R4: at most one bit, and no set bit of the word lies below it
    always_comb begin
        assert_iso_lowest_R4: assert ((iso_o & (iso_o - WORD_W'(1))) == '0
            && (word_i == '0 || ((word_i & iso_o) != '0
                                 && (word_i & (iso_o - WORD_W'(1))) == '0)));
    end

endmodule

// File: rtl/sbs_onehot_enc.sv
module sbs_onehot_enc #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BIT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] onehot_i,
    output logic [BIT_W-1:0]  code_o
);
    for (genvar k = 0; k < BIT_W; k++) begin : g_digit
        localparam logic [63:0]       FULL = sbs_pkg::digit_mask(k);
        localparam logic [WORD_W-1:0] MASK = FULL[WORD_W-1:0];
        assign code_o[k] = |(onehot_i & MASK);
    end

endmodule

// File: rtl/sbs_fetch.sv
module sbs_fetch #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              take_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              buf_v_o,
    output logic [WORD_W-1:0] buf_word_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic              idle_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  rem;
        logic [ADDR_W-1:0] next_addr;
        logic              pend;
        logic [ADDR_W-1:0] pend_addr;
        logic              buf_v;
        logic [WORD_W-1:0] buf_word;
        logic [ADDR_W-1:0] buf_addr;
    } fetch_s;

    fetch_s f_d, f_q;
    logic   arrive;
    logic   req;

    always_comb begin
        f_d    = f_q;
        arrive = f_q.pend && (mem_rdata_i != '0);
        if (take_i) f_d.buf_v = 1'b0;
        if (arrive) begin
            f_d.buf_v    = 1'b1;
            f_d.buf_word = mem_rdata_i;
            f_d.buf_addr = f_q.pend_addr;
        end
        // issue only when the slot will be free as the data lands
        req      = (f_q.rem != '0) && !f_d.buf_v;
        f_d.pend = req;
        if (req) begin
            f_d.pend_addr = f_q.next_addr;
            f_d.next_addr = f_q.next_addr + ADDR_W'(1);
            f_d.rem       = f_q.rem - CNT_W'(1);
        end
        if (load_i) begin
            f_d.rem       = count_i;
            f_d.next_addr = base_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mem_req_o  = req;
    assign mem_addr_o = f_q.next_addr;
    assign buf_v_o    = f_q.buf_v;
    assign buf_word_o = f_q.buf_word;
    assign buf_addr_o = f_q.buf_addr;
    assign idle_o     = (f_q.rem == '0) && !f_q.pend && !f_q.buf_v;

    // R7: a returning nonzero word never lands on an occupied slot
    assert_slot_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.pend && mem_rdata_i != '0) |-> !f_q.buf_v);

endmodule

// File: rtl/sparse_bit_scanner.sv
module sparse_bit_scanner #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned BIT_W = $clog2(WORD_W),
    localparam int unsigned CNT_W = ADDR_W + 1,
    localparam int unsigned POS_W = ADDR_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [POS_W-1:0]  out_pos_o,
    output logic              out_last_o
);
    import sbs_pkg::*;

    typedef struct packed {
        scan_mode_e        mode;
        logic              any;
        logic [WORD_W-1:0] work;
        logic [ADDR_W-1:0] work_addr;
        logic              hold_v;
        logic [POS_W-1:0]  hold_pos;
    } core_s;

    core_s s_d, s_q;

    logic              accept, take, fire, room, extract, exhausted, finish, work_nz;
    logic              fetch_idle, buf_v;
    logic [WORD_W-1:0] buf_word, iso, rest, work_after;
    logic [ADDR_W-1:0] buf_addr;
    logic [BIT_W-1:0]  bit_code;

    sbs_lowbit #(.WORD_W(WORD_W)) u_lowbit (
        .word_i (s_q.work),
        .iso_o  (iso),
        .rest_o (rest)
    );

    sbs_onehot_enc #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_enc (
        .onehot_i (iso),
        .code_o   (bit_code)
    );

    sbs_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .base_i      (base_i),
        .count_i     (count_i),
        .take_i      (take),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .buf_v_o     (buf_v),
        .buf_word_o  (buf_word),
        .buf_addr_o  (buf_addr),
        .idle_o      (fetch_idle)
    );

    always_comb begin
        s_d        = s_q;
        work_nz    = (s_q.work != '0);
        exhausted  = fetch_idle && !work_nz;
        out_valid_o = s_q.hold_v && (work_nz || exhausted);
        out_last_o  = s_q.hold_v && exhausted;
        out_pos_o   = s_q.hold_pos;
        fire       = out_valid_o && out_ready_i;
        room       = !s_q.hold_v || fire;
        extract    = work_nz && room;
        work_after = extract ? rest : s_q.work;
        take       = buf_v && (work_after == '0);
        s_d.work      = take ? buf_word : work_after;
        s_d.work_addr = take ? buf_addr : s_q.work_addr;
        if (extract) begin
            s_d.hold_v   = 1'b1;
            s_d.hold_pos = {s_q.work_addr, bit_code};
            s_d.any      = 1'b1;
        end else if (fire) begin
            s_d.hold_v = 1'b0;
        end
        finish = (s_q.mode == SCAN_BUSY) && exhausted && !s_q.hold_v;
        done_o = finish && !s_q.any;
        if (finish) s_d.mode = SCAN_IDLE;
        accept = start_i && (s_q.mode == SCAN_IDLE);
        if (accept) begin
            s_d.mode = SCAN_BUSY;
            s_d.any  = 1'b0;
        end
        busy_o = (s_q.mode == SCAN_BUSY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // order tracking for the in-word ordering check
    logic             prev_v_q;
    logic [POS_W-1:0] prev_pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            prev_v_q   <= 1'b0;
            prev_pos_q <= '0;
        end else if (fire) begin
            prev_v_q   <= 1'b1;
            prev_pos_q <= out_pos_o;
        end
    end

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_pos_o) && $stable(out_last_o)));

    assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last_o) |=> !out_valid_o);

    assert_inword_rising_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && prev_v_q && prev_pos_q[POS_W-1:BIT_W] == out_pos_o[POS_W-1:BIT_W])
            |-> (out_pos_o > prev_pos_q));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!out_valid_o && !mem_req_o));

endmodule

// File: tb/sparse_bit_scanner_tb.sv
module sparse_bit_scanner_tb;
    localparam int AW    = 6;
    localparam int WW    = 32;
    localparam int NWORD = 1 << AW;
    localparam int PW    = AW + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW:0]   count_i = '0;
    logic          busy_o, done_o, mem_req_o, out_valid_o, out_last_o;
    logic          out_ready_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [WW-1:0] mem_rdata_i = '0;
    logic [PW-1:0] out_pos_o;

    logic [WW-1:0] bmem [NWORD];
    int            exp_pos [NWORD*WW];
    int            exp_n;
    int            n_checks = 0;
    int            n_fail = 0;
    int            cycles = 0;
    int            last_span;
    int            last_wait;
    bit            saw_req;

    always #4 clk = ~clk;

    sparse_bit_scanner #(.WORD_W(WW), .ADDR_W(AW)) u_dut (
        .clk, .rst_n, .start_i, .base_i, .count_i, .busy_o, .done_o,
        .mem_req_o, .mem_addr_o, .mem_rdata_i,
        .out_valid_o, .out_ready_i, .out_pos_o, .out_last_o
    );

    always @(posedge clk) begin
        if (mem_req_o) mem_rdata_i <= bmem[mem_addr_o];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [WW-1:0] sparse_word();
        logic [WW-1:0] w = '0;
        if ($urandom % 3 == 0) w[$urandom % WW] = 1'b1;
        if ($urandom % 6 == 0) w[$urandom % WW] = 1'b1;
        return w;
    endfunction

    task automatic build_expect(input int base, input int cnt);
        exp_n = 0;
        for (int w = 0; w < cnt; w++) begin
            int a = (base + w) % NWORD;
            for (int b = 0; b < WW; b++)
                if (bmem[a][b]) begin
                    exp_pos[exp_n] = a * WW + b;
                    exp_n++;
                end
        end
    endtask

    // ready_pct: chance in percent that out_ready_i is high in a cycle
    task automatic run_scan(input int base, input int cnt, input int ready_pct,
                            input bit poke, input string tag);
        int  got = 0;
        int  it = 0;
        int  first_c = -1;
        int  done_at = -1;
        int  done_cnt = 0;
        bit  p_valid = 0, p_ready = 0, p_last = 0;
        int  p_pos = 0;
        bit  ended = 0;
        build_expect(base, cnt);
        saw_req = 0;
        @(negedge clk);
        start_i = 1'b1;
        base_i  = AW'(base);
        count_i = (AW+1)'(cnt);
        while (!ended && it < 20000) begin
            @(negedge clk);
            start_i = (poke && it == 3);
            if (poke && it == 3) begin
                base_i  = AW'(base + 7);
                count_i = 1;
            end
            out_ready_i = (($urandom % 100) < ready_pct);
            #1;
            if (mem_req_o) saw_req = 1;
            if (p_valid && !p_ready)
                check(out_valid_o && out_pos_o == PW'(p_pos) && out_last_o == p_last,
                      {"R5 hold ", tag}, int'(out_pos_o), p_pos);
            if (done_o) begin
                done_cnt++;
                done_at = it;
            end
            if (out_valid_o && out_ready_i) begin
                if (first_c < 0) first_c = it;
                last_span = it - first_c;
                if (got < exp_n) begin
                    check(int'(out_pos_o) == exp_pos[got], {"R2/R3 position ", tag},
                          int'(out_pos_o), exp_pos[got]);
                    check(out_last_o == (got == exp_n - 1), {"R6 last flag ", tag},
                          int'(out_last_o), int'(got == exp_n - 1));
                end else begin
                    check(0, {"R2 extra index ", tag}, int'(out_pos_o), -1);
                end
                got++;
                if (out_last_o) ended = 1;
            end
            if (done_o) ended = 1;
            p_valid = out_valid_o;
            p_ready = out_ready_i;
            p_last  = out_last_o;
            p_pos   = int'(out_pos_o);
            it++;
        end
        last_wait = done_at;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            out_ready_i = 1'b1;
            #1;
            if (done_o) done_cnt++;
            check(!out_valid_o, {"R6 nothing after end ", tag}, int'(out_valid_o), 0);
        end
        check(got == exp_n, {"R2 count ", tag}, got, exp_n);
        check(done_cnt == (exp_n == 0 ? 1 : 0), {"R9 done pulse ", tag}, done_cnt,
              exp_n == 0 ? 1 : 0);
        check(!busy_o, {"R9 idle after scan ", tag}, int'(busy_o), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NWORD; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid_o && !mem_req_o && !done_o && !busy_o, "R1 reset",
              int'({out_valid_o, mem_req_o, done_o, busy_o}), 0);
        rst_n = 1'b1;

        // R8: empty count
        run_scan(9, 0, 100, 0, "empty");
        check(!saw_req, "R8 no read on zero count", int'(saw_req), 0);

        // R7: all-zero run
        run_scan(3, 10, 100, 0, "zeros");
        check(last_wait >= 0 && last_wait <= 10 + 4, "R7 zero-word speed", last_wait, 14);
        check(saw_req, "R7 reads issued", int'(saw_req), 1);

        // R2/R6: single MSB-only word
        bmem[5] = 32'h8000_0000;
        run_scan(5, 1, 100, 0, "msb");

        // R11: dense all-ones, back to back
        for (int i = 20; i < 24; i++) bmem[i] = '1;
        run_scan(20, 4, 100, 0, "ones");
        check(last_span == 4 * WW - 1, "R11 back-to-back", last_span, 4 * WW - 1);

        // R2 wrap of the word address
        for (int i = 0; i < NWORD; i++) bmem[i] = sparse_word();
        bmem[62] = 32'h0000_0001;
        bmem[1]  = 32'h8000_0001;
        run_scan(60, 8, 60, 0, "wrap");

        // R3/R5: full sparse map under random backpressure
        run_scan(0, 64, 40, 0, "sparse");

        // R10: dense random words with a start pulse mid-scan
        for (int i = 0; i < NWORD; i++) bmem[i] = $urandom | $urandom;
        run_scan(10, 6, 70, 1, "dense-poke");

        // more random short scans
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < NWORD; i++)
                bmem[i] = (r % 3 == 0) ? ($urandom | $urandom) : sparse_word();
            run_scan($urandom % NWORD, 1 + $urandom % 20, 20 + $urandom % 80, 0, "random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule